// File: doc/BRIEF.md
# Coherent Split-Write DAC Code Register

This block holds the output codes for a set of digital-to-analog converter channels (two by default, 12 bits each) that software programs over a narrow byte-wide register bus. A code is wider than the bus, so each channel takes two byte addresses: one for the upper nibble and one for the lower byte. The upper part goes into a hidden staging register. Writing the lower byte moves the staged nibble and the new byte into the active code register as one step. The converter therefore never sees a code that is half old and half new.

Software writes the upper part first and the lower byte second. A lower-byte write that has no new upper-part write before it reuses the nibble that is already staged, so software can make quick fine-grained changes with a single bus cycle. Both registers read back. Reads are combinational on the address.

Top module: `dac_code_regs`

## Requirements
- R1: After reset, every active code, every staged nibble and every readback value are zero.
- R2: A write to a channel's upper address (address 2*c) captures only bits [3:0] of the write data into that channel's staging nibble. It leaves the active code of every channel unchanged.
- R3: A write to a channel's lower address (address 2*c+1) sets that channel's active code, on the clock edge of the write, to {staged nibble, write byte}.
- R4: A read of the upper address returns the staged nibble in bits [3:0] and zeros in bits [7:4].
- R5: A read of the lower address returns bits [7:0] of the channel's active code.
- R6: Repeated lower-byte writes with no upper write between them reuse the nibble that was last staged.
- R7: Writes addressed to one channel never change the staged nibble or the active code of another channel.
- R8: Addresses at or above 2*NUM_CH are unmapped: writes to them change nothing, and reads from them return zero.
- R9: With the write strobe low, no active code changes, whatever the address and data inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | ADDR_W (3) | Register address: upper part of channel c at 2*c, lower byte at 2*c+1 |
| bus_wdata | input | BUS_W (8) | Write data |
| bus_rdata | output | BUS_W (8) | Combinational readback for bus_addr |
| code_out | output | NUM_CH*CODE_W (24) | Active codes; channel c sits in bits [c*CODE_W +: CODE_W] |

## Verification
On every cycle the assertions check three things. An upper-part write leaves the active code unchanged. A lower-byte write commits exactly the nibble that was staged the cycle before, together with the written byte. An idle bus or an unmapped address leaves every code unchanged, and the readback mux matches the staged and active state. Two things only the bench's scenarios can show: that the write ordering gives the intended 12-bit values end to end, including a nibble reused after several lower-byte writes and a nibble cleared by reset, and that the data bits above the nibble in an upper-part write are dropped.

// File: rtl/dac_regs_pkg.sv
package dac_regs_pkg;

  // Which half of a channel code a decoded address selects
  typedef enum logic [0:0] {
    PART_UPPER = 1'b0,
    PART_LOWER = 1'b1
  } code_part_e;

  // Address of the upper part of channel ch
  function automatic int upper_addr(input int ch);
    return 2 * ch;
  endfunction

  // Address of the lower byte of channel ch
  function automatic int lower_addr(input int ch);
    return 2 * ch + 1;
  endfunction

endpackage

// File: rtl/dac_addr_decode.sv
module dac_addr_decode #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_CH-1:0] hi_we,
  output logic [NUM_CH-1:0] lo_we
);
  import dac_regs_pkg::*;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign hi_we[c] = bus_wr && (bus_addr == ADDR_W'(upper_addr(c)));
    assign lo_we[c] = bus_wr && (bus_addr == ADDR_W'(lower_addr(c)));
  end

endmodule

// File: rtl/dac_channel_reg.sv
module dac_channel_reg #(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8,
  localparam int HI_W  = CODE_W - BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [BUS_W-1:0]  wdata,
  output logic [HI_W-1:0]   staged_hi,
  output logic [CODE_W-1:0] active_code
);

  // Join the staged upper part and a fresh lower byte into a full code
  function automatic logic [CODE_W-1:0] join_code(input logic [HI_W-1:0] hi,
                                                  input logic [BUS_W-1:0] lo);
    return {hi, lo};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_hi   <= '0;
      active_code <= '0;
    end else begin
      if (hi_we) staged_hi <= wdata[HI_W-1:0];
      if (lo_we) active_code <= join_code(staged_hi, wdata);
    end
  end

endmodule

// File: rtl/dac_readback_mux.sv
module dac_readback_mux #(
  parameter int NUM_CH = 2,
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 3,
  localparam int HI_W  = CODE_W - BUS_W
) (
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [NUM_CH*HI_W-1:0]   staged_flat,
  input  logic [NUM_CH*CODE_W-1:0] code_flat,
  output logic [BUS_W-1:0]         bus_rdata
);
  import dac_regs_pkg::*;

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(upper_addr(c)))
        bus_rdata = BUS_W'(staged_flat[c*HI_W +: HI_W]);
      if (bus_addr == ADDR_W'(lower_addr(c)))
        bus_rdata = code_flat[c*CODE_W +: BUS_W];
    end
  end

endmodule

// File: rtl/dac_code_regs.sv
module dac_code_regs #(
  parameter int NUM_CH = 2,
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [BUS_W-1:0]         bus_wdata,
  output logic [BUS_W-1:0]         bus_rdata,
  output logic [NUM_CH*CODE_W-1:0] code_out
);
  localparam int HI_W = CODE_W - BUS_W;

  // Named internal events for the checker
  logic [NUM_CH-1:0]      hi_we;
  logic [NUM_CH-1:0]      lo_we;
  logic [NUM_CH*HI_W-1:0] staged_flat;

  dac_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .hi_we   (hi_we),
    .lo_we   (lo_we)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dac_channel_reg #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .hi_we      (hi_we[c]),
      .lo_we      (lo_we[c]),
      .wdata      (bus_wdata),
      .staged_hi  (staged_flat[c*HI_W +: HI_W]),
      .active_code(code_out[c*CODE_W +: CODE_W])
    );
  end

  dac_readback_mux #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .BUS_W(BUS_W),
                     .ADDR_W(ADDR_W)) u_rdmux (
    .bus_addr   (bus_addr),
    .staged_flat(staged_flat),
    .code_flat  (code_out),
    .bus_rdata  (bus_rdata)
  );

endmodule

// File: rtl/dac_code_regs_chk.sv
module dac_code_regs_chk #(
  parameter int NUM_CH = 2,
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 3,
  localparam int HI_W  = CODE_W - BUS_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [BUS_W-1:0]         bus_wdata,
  input logic [BUS_W-1:0]         bus_rdata,
  input logic [NUM_CH*CODE_W-1:0] code_out,
  input logic [NUM_CH-1:0]        hi_we,
  input logic [NUM_CH-1:0]        lo_we,
  input logic [NUM_CH*HI_W-1:0]   staged_flat
);
  logic unmapped;
  assign unmapped = int'(bus_addr) >= 2 * NUM_CH;

  // R9: idle bus keeps every code
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(code_out));

  // R8: unmapped writes change nothing and read as zero
  p_unmapped_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && unmapped) |=> ($stable(code_out) && $stable(staged_flat)));
  p_unmapped_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> bus_rdata == '0);
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_we, lo_we}));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2: upper write leaves active code alone
    p_upper_keeps_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hi_we[c] |=> $stable(code_out[c*CODE_W +: CODE_W]));
    // R3 / R6: lower write commits the nibble staged before it
    p_lower_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we[c] |=> code_out[c*CODE_W +: CODE_W] ==
                   {$past(staged_flat[c*HI_W +: HI_W]), $past(bus_wdata)});
    // R6: lower write does not disturb the staged nibble
    p_lower_keeps_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we[c] |=> $stable(staged_flat[c*HI_W +: HI_W]));
    // R4: upper readback
    p_upper_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bus_addr) == 2*c) |-> bus_rdata == BUS_W'(staged_flat[c*HI_W +: HI_W]));
    // R5: lower readback
    p_lower_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bus_addr) == 2*c+1) |-> bus_rdata == code_out[c*CODE_W +: BUS_W]);
  end

endmodule

bind dac_code_regs dac_code_regs_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .code_out   (code_out),
  .hi_we      (hi_we),
  .lo_we      (lo_we),
  .staged_flat(staged_flat)
);

// File: tb/dac_code_regs_bench.sv
module dac_code_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] code_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_code_regs u_dac_code_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .code_out(code_out)
  );

  // {wr, addr, wdata, expected ch1 code, expected ch0 code} after the cycle
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 8'h0A, 12'h000, 12'h000},  // R2 stage ch0
    {1'b1, 3'd1, 8'h5C, 12'h000, 12'hA5C},  // R3 commit ch0
    {1'b1, 3'd2, 8'h03, 12'h000, 12'hA5C},  // R2 stage ch1
    {1'b1, 3'd3, 8'hFF, 12'h3FF, 12'hA5C},  // R3 R7 commit ch1
    {1'b1, 3'd1, 8'h11, 12'h3FF, 12'hA11},  // R6 reuse nibble
    {1'b1, 3'd0, 8'hF7, 12'h3FF, 12'hA11},  // R2 high data bits dropped
    {1'b0, 3'd1, 8'h99, 12'h3FF, 12'hA11},  // R9 idle
    {1'b1, 3'd5, 8'h77, 12'h3FF, 12'hA11},  // R8 unmapped write
    {1'b1, 3'd1, 8'h00, 12'h3FF, 12'h700},  // R3 nibble 7
    {1'b1, 3'd2, 8'h0C, 12'h3FF, 12'h700},  // R7 stage ch1
    {1'b1, 3'd3, 8'h80, 12'hC80, 12'h700}   // R3 commit ch1
  };

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic wr, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_at(input string tag, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    check(tag, {16'h0, bus_rdata}, {16'h0, exp});
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 codes after reset", code_out, 24'h0);
    read_at("R1 readback upper after reset", 3'd0, 8'h00);
    read_at("R1 readback lower after reset", 3'd3, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      bus_cycle(VEC[i][35], VEC[i][34:32], VEC[i][31:24]);
      check($sformatf("R2/R3/R6/R7/R8/R9 vector %0d", i), code_out, VEC[i][23:0]);
    end

    // Readback after the table: ch0 staged 7, active 700; ch1 staged C, active C80
    read_at("R4 upper ch0", 3'd0, 8'h07);
    read_at("R5 lower ch0", 3'd1, 8'h00);
    read_at("R4 upper ch1", 3'd2, 8'h0C);
    read_at("R5 lower ch1", 3'd3, 8'h80);
    read_at("R8 unmapped read", 3'd6, 8'h00);

    // Reset mid-run clears staging as well as active codes
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 codes after mid reset", code_out, 24'h0);
    read_at("R1 staged cleared", 3'd2, 8'h00);
    rst_n = 1'b1;
    bus_cycle(1'b1, 3'd1, 8'h34);
    check("R6 cleared nibble reused", code_out, 24'h000034);
    bus_cycle(1'b1, 3'd1, 8'h35);
    check("R6 second lower write", code_out, 24'h000035);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule